// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a programmable watchdog that software services through a small register port. A down-counter is loaded from a 10-bit timer value and loses one step on each pulse of a tick-enable input. The tick source sits outside the block. At the intended tick of 0.6 s, a timeout of N seconds is programmed as N*10/6 ticks. When the count runs out, a first-timeout status flag is raised, the counter reloads itself and keeps running. If the count runs out a second time without a reload, the block records a second-timeout and a boot status. It also asks the system for an action, unless the no-reboot input is set. The action policy itself, such as pause, reset or shutdown, is decided outside.

Software reaches the registers by byte offset with 8-, 16- or 32-bit accesses. A wide access covers consecutive byte offsets in little-endian order. It can read and write the following registers:
- the live count, where any write reloads the counter
- the timer value
- a data-in byte and a data-out byte, each of which raises a status flag when written
- two status words, all of whose bits are write-1-to-clear
- two control words: the first holds a halt bit and a lock bit that stays set once written
- two message bytes, a watchdog-count byte and a software interrupt byte, which are plain storage

The register port has no handshake. A write takes effect at the clock edge where `wr_i` is high. Read data is a combinational function of `addr_i` and `size_i`, so a read is never back-pressured.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, every register reads as follows:
  - count 0 and timer value 0x0004
  - both status words 0x0000
  - control word 1 0x0000 and control word 2 0x0008
  - software interrupt byte 0x03
  - data, message and watchdog-count bytes 0x00
  - `timeout_o`, `sw_irq_o` and `action_req_o` low
- R2: A write of any size that touches byte offset 0x00 or 0x01 loads the counter from the timer value at that edge. While running, the count read at offset 0x00 drops by one on each tick-enable cycle.
- R3: While the halt bit (control word 1 at offset 0x08, bit 11) is set, ticks leave the count unchanged. Clearing the bit resumes the countdown.
- R4: Expiry happens on a tick taken while the count is 1 or 0. At that edge the count reloads from the timer value and status word 1 (offset 0x04) bit 3 sets; `timeout_o` mirrors it. With a timer value of 1023, the count reads 1 with bit 3 clear after 1022 ticks, and bit 3 sets on tick 1023.
- R5: The second expiry since the last reload sets status word 2 (offset 0x06) bits 1 and 2. This holds even if status word 1 bit 3 was cleared in between. The two-expiry sequence then starts over.
- R6: On a second expiry, `action_req_o` is high for exactly one cycle, the cycle after that expiry edge. This only happens if `no_reboot_i` was low at that edge; with `no_reboot_i` high, only the status bits change.
- R7: Status bits clear only when a 1 is written to them. Writing 0 leaves them unchanged, and writing back the value just read leaves the status word at zero.
- R8: The lock bit (control word 1 bit 12) is sticky: once written to 1 it stays 1 until reset, whatever is written later.
- R9: A write to the data-in byte (offset 0x02) sets status word 1 bit 1. A write to the data-out byte (offset 0x03) sets status word 1 bit 2. `sw_irq_o` is high while either bit is set.
- R10: Wide reads pack higher offsets into higher bits:
  - a 16-bit read at offset 0x02 returns data-out above data-in
  - 32-bit reads at offsets 0x04 and 0x08 return status word 2 above status word 1, and control word 2 above control word 1
- R11: The timer value (offset 0x12) holds 10 bits. Its upper bits read as zero.
- R12: A reload write in the same cycle as a tick loads the timer value, and the decrement is dropped.
- R13: A reload write restarts the two-expiry sequence, so the next expiry after a reload counts as a first expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 5 | Byte offset of the access |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 or 3 dword |
| wr_i | input | 1 | Write strobe for the current access |
| wdata_i | input | 32 | Write data, lowest byte to lowest offset |
| rdata_o | output | 32 | Combinational read data, unused upper bytes zero |
| tick_i | input | 1 | Tick enable, one countdown step per high cycle |
| no_reboot_i | input | 1 | Suppresses the system action request when high |
| timeout_o | output | 1 | First-timeout status flag |
| sw_irq_o | output | 1 | Data-port interrupt flag |
| action_req_o | output | 1 | One-cycle second-timeout action request |

## Verification
The hardest states to reach are the two ends of a long countdown: a count of exactly 1 one tick before expiry, and the second expiry after a maximum-length period. To reach them, the bench holds tick-enable high for computed runs of 1022, 1, and 1023 cycles. It clears the first-timeout flag between the two runs, so the second-stage bits have to come from the block's internal expiry memory rather than from the visible flag. The reload-versus-tick collision needs the write strobe and the tick in the same cycle, which a dedicated directed step drives. Random timer values and partial tick counts then probe the decrement across many periods.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W    = 5;
  localparam int REG_BYTES = 20;
  localparam int OFF_RLD   = 0;
  localparam int OFF_DIN   = 2;
  localparam int OFF_DOUT  = 3;
  localparam int OFF_STS1  = 4;
  localparam int OFF_STS2  = 6;
  localparam int OFF_CTL1  = 8;
  localparam int OFF_CTL2  = 10;
  localparam int OFF_MSG1  = 12;
  localparam int OFF_MSG2  = 13;
  localparam int OFF_WDCNT = 14;
  localparam int OFF_SWIRQ = 16;
  localparam int OFF_TMR   = 18;
  localparam int S1_SMI  = 1;
  localparam int S1_INT  = 2;
  localparam int S1_TMO  = 3;
  localparam int S2_SEC  = 1;
  localparam int S2_BOOT = 2;
  localparam int C1_HALT = 11;
  localparam int C1_LOCK = 12;
  localparam logic [15:0] CTL2_RST  = 16'h0008;
  localparam logic [7:0]  SWIRQ_RST = 8'h03;
  localparam int          TMR_RST   = 4;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} xfer_size_e;
endpackage

// File: rtl/wdt_bus_lanes.sv
module wdt_bus_lanes
  import wdt_pkg::*;
#(
  parameter int NB = 20,
  parameter int AW = 5
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      size_i,
  input  logic            wr_i,
  input  logic [31:0]     wdata_i,
  output logic [NB-1:0]   wstb_o,
  output logic [NB*8-1:0] wbytes_o,
  input  logic [NB*8-1:0] rbytes_i,
  output logic [31:0]     rdata_o
);
  logic [2:0] nbytes;
  always_comb begin
    case (size_i)
      SZ_BYTE: nbytes = 3'd1;
      SZ_WORD: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  // Write side: each register byte finds its lane within the access window.
  for (genvar i = 0; i < NB; i++) begin : g_wlane
    logic [AW:0]  offv;
    logic [31:0]  wsh;
    assign offv = (AW+1)'(i) - {1'b0, addr_i};
    assign wstb_o[i] = wr_i && (offv < {{(AW-2){1'b0}}, nbytes});
    assign wsh = wdata_i >> {offv[1:0], 3'b000};
    assign wbytes_o[i*8 +: 8] = wsh[7:0];
  end

  // Read side: lane k returns byte addr+k when inside the access and the map.
  for (genvar k = 0; k < 4; k++) begin : g_rlane
    logic [AW:0]     idx;
    logic [NB*8-1:0] rsh;
    assign idx = {1'b0, addr_i} + (AW+1)'(k);
    assign rsh = rbytes_i >> {idx, 3'b000};
    assign rdata_o[k*8 +: 8] = ((3'(k) < nbytes) && (idx < (AW+1)'(NB))) ? rsh[7:0] : 8'h00;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          halt_i,
  input  logic          reload_i,
  input  logic [CW-1:0] tmr_i,
  input  logic          no_reboot_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o,
  output logic          second_o,
  output logic          action_req_o
);
  logic armed_q;
  logic step;

  assign step     = tick_i && !halt_i && !reload_i;
  assign expire_o = step && (count_o <= CW'(1));
  assign second_o = expire_o && armed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_o      <= '0;
      armed_q      <= 1'b0;
      action_req_o <= 1'b0;
    end else begin
      action_req_o <= 1'b0;
      if (reload_i) begin
        count_o <= tmr_i;
        armed_q <= 1'b0;
      end else if (expire_o) begin
        count_o      <= tmr_i;
        armed_q      <= !armed_q;
        action_req_o <= armed_q && !no_reboot_i;
      end else if (step) begin
        count_o <= count_o - CW'(1);
      end
    end
  end

  p_halt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(count_o));
  p_reload_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (count_o == $past(tmr_i)));
  p_decrement_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !reload_i && count_o > CW'(1)) |=> (count_o == $past(count_o) - CW'(1)));
  p_action_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_req_o |-> !$past(no_reboot_i));
  p_action_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_req_o |=> !action_req_o);
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        expire_i,
  input  logic        second_i,
  input  logic        smi_set_i,
  input  logic        int_set_i,
  input  logic        clr1_stb_i,
  input  logic [7:0]  clr1_i,
  input  logic        clr2_stb_i,
  input  logic [7:0]  clr2_i,
  output logic [15:0] sts1_o,
  output logic [15:0] sts2_o
);
  logic tmo_q, smi_q, int_q, sec_q, boot_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tmo_q  <= 1'b0;
      smi_q  <= 1'b0;
      int_q  <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      // Set wins over a simultaneous write-1-to-clear.
      tmo_q  <= expire_i  | (tmo_q  & !(clr1_stb_i & clr1_i[S1_TMO]));
      smi_q  <= smi_set_i | (smi_q  & !(clr1_stb_i & clr1_i[S1_SMI]));
      int_q  <= int_set_i | (int_q  & !(clr1_stb_i & clr1_i[S1_INT]));
      sec_q  <= second_i  | (sec_q  & !(clr2_stb_i & clr2_i[S2_SEC]));
      boot_q <= second_i  | (boot_q & !(clr2_stb_i & clr2_i[S2_BOOT]));
    end
  end

  always_comb begin
    sts1_o = '0;
    sts1_o[S1_TMO] = tmo_q;
    sts1_o[S1_SMI] = smi_q;
    sts1_o[S1_INT] = int_q;
    sts2_o = '0;
    sts2_o[S2_SEC]  = sec_q;
    sts2_o[S2_BOOT] = boot_q;
  end

  p_timeout_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> sts1_o[S1_TMO]);
  p_second_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_i |=> (sts2_o[S2_SEC] && sts2_o[S2_BOOT]));
  p_no_spurious_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !(clr1_stb_i && clr1_i[S1_TMO])) |=> sts1_o[S1_TMO]);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tick_i,
  input  logic        no_reboot_i,
  output logic        timeout_o,
  output logic        sw_irq_o,
  output logic        action_req_o
);
  localparam int TMR_HI_W = CW - 8;

  logic [REG_BYTES-1:0]   wstb;
  logic [REG_BYTES*8-1:0] wb;
  logic [REG_BYTES*8-1:0] rb;

  logic [7:0]    din_q, dout_q, msg1_q, msg2_q, wdcnt_q, swirq_q;
  logic [15:0]   ctl2_q;
  logic [CW-1:0] tmr_q;
  logic          halt_q, lock_q;
  logic [CW-1:0] count;
  logic          expire, second, reload;
  logic [15:0]   sts1, sts2;
  logic [7:0]    ctl1_hi_wr;

  wdt_bus_lanes #(.NB(REG_BYTES), .AW(ADDR_W)) u_lanes (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .wstb_o   (wstb),
    .wbytes_o (wb),
    .rbytes_i (rb),
    .rdata_o  (rdata_o)
  );

  assign reload     = wstb[OFF_RLD] | wstb[OFF_RLD+1];
  assign ctl1_hi_wr = wb[(OFF_CTL1+1)*8 +: 8];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      din_q   <= '0;
      dout_q  <= '0;
      msg1_q  <= '0;
      msg2_q  <= '0;
      wdcnt_q <= '0;
      swirq_q <= SWIRQ_RST;
      ctl2_q  <= CTL2_RST;
      tmr_q   <= CW'(TMR_RST);
      halt_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (wstb[OFF_DIN])    din_q   <= wb[OFF_DIN*8 +: 8];
      if (wstb[OFF_DOUT])   dout_q  <= wb[OFF_DOUT*8 +: 8];
      if (wstb[OFF_MSG1])   msg1_q  <= wb[OFF_MSG1*8 +: 8];
      if (wstb[OFF_MSG2])   msg2_q  <= wb[OFF_MSG2*8 +: 8];
      if (wstb[OFF_WDCNT])  wdcnt_q <= wb[OFF_WDCNT*8 +: 8];
      if (wstb[OFF_SWIRQ])  swirq_q <= wb[OFF_SWIRQ*8 +: 8];
      if (wstb[OFF_CTL2])   ctl2_q[7:0]  <= wb[OFF_CTL2*8 +: 8];
      if (wstb[OFF_CTL2+1]) ctl2_q[15:8] <= wb[(OFF_CTL2+1)*8 +: 8];
      if (wstb[OFF_TMR])    tmr_q[7:0]   <= wb[OFF_TMR*8 +: 8];
      if (wstb[OFF_TMR+1])  tmr_q[CW-1:8] <= wb[(OFF_TMR+1)*8 +: TMR_HI_W];
      if (wstb[OFF_CTL1+1]) begin
        halt_q <= ctl1_hi_wr[C1_HALT-8];
        lock_q <= lock_q | ctl1_hi_wr[C1_LOCK-8];
      end
    end
  end

  wdt_countdown #(.CW(CW)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .halt_i       (halt_q),
    .reload_i     (reload),
    .tmr_i        (tmr_q),
    .no_reboot_i  (no_reboot_i),
    .count_o      (count),
    .expire_o     (expire),
    .second_o     (second),
    .action_req_o (action_req_o)
  );

  wdt_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .second_i   (second),
    .smi_set_i  (wstb[OFF_DIN]),
    .int_set_i  (wstb[OFF_DOUT]),
    .clr1_stb_i (wstb[OFF_STS1]),
    .clr1_i     (wb[OFF_STS1*8 +: 8]),
    .clr2_stb_i (wstb[OFF_STS2]),
    .clr2_i     (wb[OFF_STS2*8 +: 8]),
    .sts1_o     (sts1),
    .sts2_o     (sts2)
  );

  always_comb begin
    rb = '0;
    rb[OFF_RLD*8  +: 16] = {{(16-CW){1'b0}}, count};
    rb[OFF_DIN*8  +: 8]  = din_q;
    rb[OFF_DOUT*8 +: 8]  = dout_q;
    rb[OFF_STS1*8 +: 16] = sts1;
    rb[OFF_STS2*8 +: 16] = sts2;
    rb[OFF_CTL1*8 + C1_HALT] = halt_q;
    rb[OFF_CTL1*8 + C1_LOCK] = lock_q;
    rb[OFF_CTL2*8 +: 16] = ctl2_q;
    rb[OFF_MSG1*8 +: 8]  = msg1_q;
    rb[OFF_MSG2*8 +: 8]  = msg2_q;
    rb[OFF_WDCNT*8 +: 8] = wdcnt_q;
    rb[OFF_SWIRQ*8 +: 8] = swirq_q;
    rb[OFF_TMR*8  +: 16] = {{(16-CW){1'b0}}, tmr_q};
  end

  assign timeout_o = sts1[S1_TMO];
  assign sw_irq_o  = sts1[S1_SMI] | sts1[S1_INT];

  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  p_din_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstb[OFF_DIN] |=> sw_irq_o);
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        no_reboot = 1'b0;
  logic        timeout, sw_irq, action_req;
  int checks = 0, errors = 0, act_cnt = 0;

  always #5 clk = ~clk;

  wdt_two_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .no_reboot_i(no_reboot),
    .timeout_o(timeout), .sw_irq_o(sw_irq), .action_req_o(action_req)
  );

  always @(negedge clk) if (rst_n && action_req) act_cnt++;

  function automatic logic [31:0] pack16(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction
  function automatic logic [31:0] count_after(input int n, input int k);
    return 32'(n - k);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int sz, input logic [31:0] d);
    @(negedge clk);
    addr = 5'(a); size = 2'(sz); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, input int sz, output logic [31:0] v);
    @(negedge clk);
    addr = 5'(a); size = 2'(sz);
    #1 v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic arm(input logic [15:0] tv);
    wr_reg(8, 1, 32'h0800);
    wr_reg(4, 1, 32'h000E);
    wr_reg(6, 1, 32'h0006);
    wr_reg(18, 1, {16'h0, tv});
    wr_reg(0, 1, 32'h0);
    wr_reg(8, 1, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(0, 1, v);  chk("R1 count", v, 32'h0);
    rd_reg(2, 1, v);  chk("R1 data", v, 32'h0);
    rd_reg(4, 2, v);  chk("R1 status", v, 32'h0);
    rd_reg(8, 2, v);  chk("R1 control", v, pack16(16'h0008, 16'h0000));
    rd_reg(12, 1, v); chk("R1 message", v, 32'h0);
    rd_reg(14, 0, v); chk("R1 wdcnt", v, 32'h0);
    rd_reg(16, 0, v); chk("R1 swirq", v, 32'h03);
    rd_reg(18, 1, v); chk("R1 timer", v, 32'h4);
    chk("R1 outputs", {29'h0, timeout, sw_irq, action_req}, 32'h0);

    // R11 upper timer bits read zero
    wr_reg(18, 1, 32'hFFFF);
    rd_reg(18, 1, v); chk("R11 timer width", v, 32'h03FF);

    // R4 maximum period, R5 second stage after clearing first flag
    arm(16'h03FF);
    ticks(1022);
    rd_reg(0, 1, v); chk("R4 count one before expiry", v, 32'd1);
    rd_reg(4, 1, v); chk("R4 no timeout yet", v, 32'h0);
    ticks(1);
    rd_reg(4, 1, v); chk("R4 timeout set", v, 32'h0008);
    chk("R4 timeout_o", {31'h0, timeout}, 32'h1);
    rd_reg(0, 1, v); chk("R4 auto reload", v, 32'd1023);
    wr_reg(4, 1, 32'h0008);
    rd_reg(4, 1, v); chk("R7 timeout cleared", v, 32'h0);
    ticks(1023);
    rd_reg(4, 1, v); chk("R5 timeout again", v, 32'h0008);
    rd_reg(6, 1, v); chk("R5 second and boot", v, 32'h0006);
    chk("R6 action pulse count", 32'(act_cnt), 32'd1);

    // R7 write zero keeps, write-back clears
    wr_reg(6, 1, 32'h0);
    rd_reg(6, 1, v); chk("R7 zero write keeps", v, 32'h0006);
    wr_reg(6, 1, v);
    rd_reg(6, 1, v); chk("R7 write-back clears", v, 32'h0);

    // R6 no-reboot suppresses the request
    no_reboot = 1'b1;
    arm(16'd3);
    ticks(6);
    rd_reg(6, 1, v); chk("R6 status with no-reboot", v, 32'h0006);
    chk("R6 no action with no-reboot", 32'(act_cnt), 32'd1);
    no_reboot = 1'b0;

    // R13 reload restarts the sequence
    arm(16'd3);
    ticks(3);
    wr_reg(0, 0, 32'h0);
    ticks(3);
    rd_reg(6, 1, v); chk("R13 first after reload", v, 32'h0);
    ticks(3);
    rd_reg(6, 1, v); chk("R13 second after reload", v, 32'h0006);
    chk("R13 action count", 32'(act_cnt), 32'd2);

    // R3 halt freezes the count
    arm(16'd5);
    ticks(2);
    rd_reg(0, 1, v); chk("R3 running", v, count_after(5, 2));
    wr_reg(8, 1, 32'h0800);
    ticks(4);
    rd_reg(0, 1, v); chk("R3 halted", v, count_after(5, 2));
    wr_reg(8, 1, 32'h0);
    ticks(1);
    rd_reg(0, 1, v); chk("R3 resumed", v, count_after(5, 3));

    // R12 reload beats a tick in the same cycle
    @(negedge clk);
    addr = 5'd0; size = 2'd1; wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    rd_reg(0, 1, v); chk("R12 reload priority", v, 32'd5);

    // R9 / R10 data-port flags and packing
    wr_reg(8, 1, 32'h0800);
    wr_reg(4, 1, 32'h000E);
    wr_reg(6, 1, 32'h0006);
    wr_reg(2, 0, 32'h5A);
    rd_reg(4, 1, v); chk("R9 data-in flag", v, 32'h0002);
    chk("R9 sw_irq_o", {31'h0, sw_irq}, 32'h1);
    wr_reg(3, 0, 32'hA5);
    rd_reg(4, 1, v); chk("R9 data-out flag", v, 32'h0006);
    rd_reg(2, 1, v); chk("R10 data pack", v, 32'hA55A);
    wr_reg(10, 1, 32'h1234);
    rd_reg(8, 2, v); chk("R10 control pack", v, pack16(16'h1234, 16'h0800));
    rd_reg(4, 2, v); chk("R10 status pack", v, pack16(16'h0000, 16'h0006));
    wr_reg(4, 1, v);
    rd_reg(4, 1, v); chk("R7 status1 write-back", v, 32'h0);

    // R2 random periods and partial tick runs
    for (int it = 0; it < 16; it++) begin
      int n, k;
      n = 2 + int'($urandom % 60);
      k = int'($urandom % 32'(n));
      arm(16'(n));
      rd_reg(0, 1, v); chk("R2 loaded", v, 32'(n));
      if (k > 0) ticks(k);
      rd_reg(0, 1, v); chk("R2 countdown", v, count_after(n, k));
    end
    // R2 reload via upper byte only
    a0 = 1;
    wr_reg(a0, 0, 32'h0);
    rd_reg(18, 1, v);
    rd_reg(0, 1, wdata); chk("R2 upper-byte reload", wdata, v);

    // R8 sticky lock
    wr_reg(8, 1, 32'h1000);
    wr_reg(8, 1, 32'h0000);
    rd_reg(8, 1, v); chk("R8 lock sticky", v, 32'h1000);
    wr_reg(8, 1, 32'h0800);
    rd_reg(8, 1, v); chk("R8 lock with halt", v, 32'h1800);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule